// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Brake and Coast Decay

This block turns the digital commands for one full H-bridge into the four gate enables of its switches. Each output leg has a high-side and a low-side switch. The commands are a direction bit, an enable bit, a decay-select bit, a one-cycle chopper trip pulse from the current regulator, a one-cycle PWM period-start strobe and a digital flag that says the winding current has reached zero. When enabled, the bridge drives the winding in the commanded direction.

When the enable is low, or while a chopper trip is pending, the bridge decays the current. Slow decay turns both low sides on and keeps them on; this brakes the motor. Fast decay drives the bridge in the reverse of the last direction. It stops on the zero-current flag, or at the next period start if that flag never comes, and then releases every switch so the motor coasts.

A break-before-make stage in each leg keeps a high side and a low side of the same leg from ever being on together. A reset and a sleep input disable the bridge. After sleep is released, the bridge stays disabled for a programmable wake-up interval.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With run allowed, `drv_en`=1, `drv_dir`=1 and no chop pending, `br_state` becomes 1 (forward) one clock after the inputs are sampled. The gates `{gate_hs_a,gate_ls_a,gate_hs_b,gate_ls_b}` become 4'b1001 one clock after `br_state`, plus the break-before-make gap when a leg flips side.
- R2: With `drv_en`=1, `drv_dir`=0 and no chop pending, `br_state` becomes 2 (reverse) and the gates become 4'b0110.
- R3: With no drive requested and `decay_fast`=0, `br_state` becomes 3 (brake) and the gates become 4'b0101. They stay there for as long as that holds, whatever `i_zero` does.
- R4: When drive stops while in state 1 or 2 with `decay_fast`=1, `br_state` becomes 4 (fast decay). The bridge then drives opposite to the last direction: 4'b0110 after forward, 4'b1001 after reverse. When `i_zero` is sampled high in state 4, `br_state` becomes 0 (coast) and all gates turn off.
- R5: In state 4, a `pwm_start` pulse with no drive requested ends fast decay into state 0, even if `i_zero` never rose.
- R6: A `chop_trip` pulse withdraws drive even with `drv_en`=1, applying the selected decay (R3 or R4). The chop stays pending until the next `pwm_start` pulse, which restores drive in the same cycle it is sampled.
- R7: A high-side gate and a low-side gate of the same leg are never on together. A leg that moves directly from one side to the other holds both gates off for exactly `DEAD_CYC` clocks.
- R8: While `rst_n` is low, all four gates are off at once (asynchronously) and `br_state` is 5 (disabled). When `rst_n` rises with `sleep_n` high, operation starts on the first clock edge.
- R9: While `sleep_n` is low, `br_state` is 5, the gates turn off one clock later, and no other input has any effect. Once `sleep_n` rises, `br_state` stays 5 for `WAKE_CYC` more edges and then follows the inputs.
- R10: With no drive requested and `decay_fast`=1 while not driving (states 0, 3 or 5), `br_state` becomes 0 and all gates stay off; fast decay is not entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Low puts the bridge to sleep |
| drv_en | input | 1 | Drive enable, also used for PWM speed control |
| drv_dir | input | 1 | Direction: 1 forward (leg A high), 0 reverse |
| decay_fast | input | 1 | Decay select: 0 brake, 1 reverse-then-coast |
| chop_trip | input | 1 | One-cycle current-limit trip from the chopper |
| pwm_start | input | 1 | One-cycle PWM period start strobe |
| i_zero | input | 1 | Winding current has reached zero |
| gate_hs_a | output | 1 | High-side gate, leg A |
| gate_ls_a | output | 1 | Low-side gate, leg A |
| gate_hs_b | output | 1 | High-side gate, leg B |
| gate_ls_b | output | 1 | Low-side gate, leg B |
| br_state | output | 3 | Bridge state: 0 coast, 1 fwd, 2 rev, 3 brake, 4 fast decay, 5 disabled |

## Verification
`br_state` is due one edge after the inputs are sampled. The gates are due one edge after that when no leg flips side, and `DEAD_CYC` edges later again when one does. The vector walk therefore waits a settle time longer than the worst case before it compares state and gates. The break-before-make, sleep, wake and reset tests sample on the falling edge that follows each individual rising edge. They check the exact edge where a gate drops, stays off and comes back, and the exact edge where the wake interval ends.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Bridge state as reported on br_state
  typedef enum logic [2:0] {
    BR_COAST = 3'd0,
    BR_FWD   = 3'd1,
    BR_REV   = 3'd2,
    BR_BRAKE = 3'd3,
    BR_FDEC  = 3'd4,
    BR_IDLE  = 3'd5
  } br_mode_e;

  // What one leg should present
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_tgt_e;

  typedef struct packed {
    leg_tgt_e a;
    leg_tgt_e b;
  } leg_pair_t;

  // Leg targets for a bridge state; fast decay reverses the last drive
  function automatic leg_pair_t mode_to_legs(br_mode_e m, logic fd_from_fwd);
    leg_pair_t p;
    p.a = LEG_OFF;
    p.b = LEG_OFF;
    case (m)
      BR_FWD:   begin p.a = LEG_HI; p.b = LEG_LO; end
      BR_REV:   begin p.a = LEG_LO; p.b = LEG_HI; end
      BR_BRAKE: begin p.a = LEG_LO; p.b = LEG_LO; end
      BR_FDEC: begin
        if (fd_from_fwd) begin p.a = LEG_LO; p.b = LEG_HI; end
        else             begin p.a = LEG_HI; p.b = LEG_LO; end
      end
      default: ;
    endcase
    return p;
  endfunction

  // Gate pair {hs, ls} for a leg target
  function automatic logic [1:0] leg_gates(leg_tgt_e t);
    case (t)
      LEG_HI:  return 2'b10;
      LEG_LO:  return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  // True when two targets sit on opposite switches of a leg
  function automatic logic legs_oppose(leg_tgt_e x, leg_tgt_e y);
    return ((x == LEG_HI) && (y == LEG_LO)) || ((x == LEG_LO) && (y == LEG_HI));
  endfunction

endpackage

// File: rtl/hbg_wake_gate.sv
module hbg_wake_gate #(
  parameter int unsigned WAKE_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  output logic run_ok
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] wait_q;
  logic          wake_pending;

  assign wake_pending = (wait_q != '0);
  assign run_ok       = sleep_n && !wake_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wait_q <= '0;
    else if (!sleep_n)     wait_q <= CW'(WAKE_CYC);
    else if (wake_pending) wait_q <= wait_q - 1'b1;
  end

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !run_ok);

endmodule

// File: rtl/hbg_mode_fsm.sv
module hbg_mode_fsm
  import hbg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_ok,
  input  logic     drv_en,
  input  logic     drv_dir,
  input  logic     decay_fast,
  input  logic     chop_trip,
  input  logic     pwm_start,
  input  logic     i_zero,
  output br_mode_e mode_q,
  output logic     fd_from_fwd_q
);
  logic     chop_q;
  logic     chop_eff;
  logic     want_drive;
  logic     fdec_done;
  br_mode_e mode_d;
  logic     fd_d;

  // pending chop survives until a period start; a fresh trip wins
  assign chop_eff   = chop_trip || (chop_q && !pwm_start);
  assign want_drive = drv_en && !chop_eff;
  assign fdec_done  = i_zero || pwm_start;

  always_comb begin
    mode_d = mode_q;
    fd_d   = fd_from_fwd_q;
    if (!run_ok)          mode_d = BR_IDLE;
    else if (want_drive)  mode_d = drv_dir ? BR_FWD : BR_REV;
    else if (!decay_fast) mode_d = BR_BRAKE;
    else begin
      case (mode_q)
        BR_FWD:  begin mode_d = BR_FDEC; fd_d = 1'b1; end
        BR_REV:  begin mode_d = BR_FDEC; fd_d = 1'b0; end
        BR_FDEC: mode_d = fdec_done ? BR_COAST : BR_FDEC;
        default: mode_d = BR_COAST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= BR_IDLE;
      chop_q        <= 1'b0;
      fd_from_fwd_q <= 1'b0;
    end else begin
      mode_q        <= mode_d;
      chop_q        <= run_ok && chop_eff;
      fd_from_fwd_q <= fd_d;
    end
  end

  // R9
  idle_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> (mode_q == BR_IDLE));

  // R3
  brake_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BR_BRAKE) |-> $past(!decay_fast));

  // R4
  fdec_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BR_FDEC && i_zero && run_ok && !drv_en && decay_fast) |=> (mode_q == BR_COAST));

  // R6
  chop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_q && !pwm_start && run_ok) |=> (mode_q != BR_FWD && mode_q != BR_REV));

endmodule

// File: rtl/hbg_leg_stage.sv
module hbg_leg_stage
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_tgt_e tgt,
  output logic     gate_hs,
  output logic     gate_ls
);
  localparam int unsigned    GW       = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [GW-1:0]  GAP_DONE = GW'(DEAD_CYC - 1);

  leg_tgt_e      applied_q;
  leg_tgt_e      applied_d;
  leg_tgt_e      last_on_q;
  logic [GW-1:0] gap_q;
  logic          gap_met;
  logic          blocked;

  assign gap_met = (gap_q == GAP_DONE);
  assign blocked = legs_oppose(tgt, last_on_q) && !gap_met;

  // break before make: a side flip first goes through OFF
  always_comb begin
    applied_d = applied_q;
    if (tgt == LEG_OFF)             applied_d = LEG_OFF;
    else if (applied_q == LEG_OFF)  applied_d = blocked ? LEG_OFF : tgt;
    else if (tgt != applied_q)      applied_d = LEG_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q <= LEG_OFF;
      last_on_q <= LEG_OFF;
      gap_q     <= GAP_DONE;
    end else begin
      applied_q <= applied_d;
      if (applied_q != LEG_OFF && applied_d == LEG_OFF) begin
        last_on_q <= applied_q;
        gap_q     <= '0;
      end else if (applied_q == LEG_OFF && !gap_met) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign {gate_hs, gate_ls} = leg_gates(applied_q);

  // R7
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs && gate_ls));

  // R7
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ls) |-> !$past(gate_hs));

  // R7
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs) |-> !$past(gate_ls));

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3,
  parameter int unsigned WAKE_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       drv_en,
  input  logic       drv_dir,
  input  logic       decay_fast,
  input  logic       chop_trip,
  input  logic       pwm_start,
  input  logic       i_zero,
  output logic       gate_hs_a,
  output logic       gate_ls_a,
  output logic       gate_hs_b,
  output logic       gate_ls_b,
  output logic [2:0] br_state
);
  localparam int unsigned N_LEGS = 2;

  logic      run_ok;
  br_mode_e  mode_q;
  logic      fd_from_fwd;
  leg_pair_t legs;
  leg_tgt_e  leg_tgt [N_LEGS];
  logic [N_LEGS-1:0] hs_w;
  logic [N_LEGS-1:0] ls_w;

  hbg_wake_gate #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_n (sleep_n),
    .run_ok  (run_ok)
  );

  hbg_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_ok        (run_ok),
    .drv_en        (drv_en),
    .drv_dir       (drv_dir),
    .decay_fast    (decay_fast),
    .chop_trip     (chop_trip),
    .pwm_start     (pwm_start),
    .i_zero        (i_zero),
    .mode_q        (mode_q),
    .fd_from_fwd_q (fd_from_fwd)
  );

  assign legs       = mode_to_legs(mode_q, fd_from_fwd);
  assign leg_tgt[0] = legs.a;
  assign leg_tgt[1] = legs.b;

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    hbg_leg_stage #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt     (leg_tgt[g]),
      .gate_hs (hs_w[g]),
      .gate_ls (ls_w[g])
    );
  end

  assign gate_hs_a = hs_w[0];
  assign gate_ls_a = ls_w[0];
  assign gate_hs_b = hs_w[1];
  assign gate_ls_b = ls_w[1];
  assign br_state  = mode_q;

  // R9
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BR_IDLE) |=> (hs_w == '0 && ls_w == '0));

  // R1
  hs_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hs_a |-> $past(mode_q == BR_FWD || (mode_q == BR_FDEC && !fd_from_fwd)));

endmodule

// File: tb/test_hbridge_gate_ctrl.sv
module test_hbridge_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 3;
  localparam int WAKE       = 20;
  localparam int SETTLE     = DEAD + 6;
  localparam int NVEC       = 18;

  // {en,dir,dec,chop,pwm,iz}, state[2:0], gates {hs_a,ls_a,hs_b,ls_b}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b110000_001_1001,  // 0  R1 forward
    13'b100000_010_0110,  // 1  R2 reverse
    13'b000000_011_0101,  // 2  R3 brake
    13'b000001_011_0101,  // 3  R3 brake held at zero current
    13'b111000_001_1001,  // 4  R1
    13'b011000_100_0110,  // 5  R4 fast decay after forward
    13'b011001_000_0000,  // 6  R4 zero current -> coast
    13'b010000_011_0101,  // 7  R3 coast -> brake
    13'b011000_000_0000,  // 8  R10 fast from brake -> coast
    13'b101000_010_0110,  // 9  R2
    13'b101100_100_1001,  // 10 R6 chop, fast after reverse
    13'b101010_010_0110,  // 11 R6 period start restores drive
    13'b100100_011_0101,  // 12 R6 chop, slow
    13'b100001_011_0101,  // 13 R6 still pending
    13'b100010_010_0110,  // 14 R6 released
    13'b111000_001_1001,  // 15 R1
    13'b011000_100_0110,  // 16 R4
    13'b011010_000_0000   // 17 R5 period start ends fast decay
  };

  logic clk = 1'b0;
  logic rst_n, sleep_n, drv_en, drv_dir, decay_fast, chop_trip, pwm_start, i_zero;
  logic gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b;
  logic [2:0] br_state;
  wire  [3:0] gates = {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b};

  int applied_n = 0;
  int bad_n     = 0;
  bit done      = 1'b0;
  bit overlap   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_ctrl #(.DEAD_CYC(DEAD), .WAKE_CYC(WAKE)) i_hbridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .drv_en(drv_en), .drv_dir(drv_dir),
    .decay_fast(decay_fast), .chop_trip(chop_trip), .pwm_start(pwm_start), .i_zero(i_zero),
    .gate_hs_a(gate_hs_a), .gate_ls_a(gate_ls_a), .gate_hs_b(gate_hs_b), .gate_ls_b(gate_ls_b),
    .br_state(br_state)
  );

  always @(negedge clk)
    if ((gate_hs_a && gate_ls_a) || (gate_hs_b && gate_ls_b)) overlap = 1'b1;

  function automatic string vec_req(int i);
    case (i)
      0, 4, 15:               return "R1";
      1, 9:                   return "R2";
      2, 3, 7:                return "R3";
      5, 6, 16:               return "R4";
      8:                      return "R10";
      10, 11, 12, 13, 14:     return "R6";
      default:                return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    applied_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      applied_n++;
      bad_n++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied_n, bad_n);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_n = 1'b1; drv_en = 1'b0; drv_dir = 1'b0;
    decay_fast = 1'b0; chop_trip = 1'b0; pwm_start = 1'b0; i_zero = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset state", 8'(br_state), 8'd5);
    chk("R8 reset gates", 8'(gates), 8'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk) {drv_en, drv_dir, decay_fast, chop_trip, pwm_start, i_zero} = VEC[i][12:7];
      @(negedge clk) begin chop_trip = 1'b0; pwm_start = 1'b0; end
      repeat (SETTLE) @(negedge clk);
      chk({vec_req(i), " state"}, 8'(br_state), 8'(VEC[i][6:4]));
      chk({vec_req(i), " gates"}, 8'(gates), 8'(VEC[i][3:0]));
    end

    // R7 break-before-make on a direction flip
    @(negedge clk) begin drv_en = 1'b1; drv_dir = 1'b1; decay_fast = 1'b0; i_zero = 1'b0; end
    repeat (SETTLE) @(negedge clk);
    chk("R1 pre-flip", 8'(gates), 8'h9);
    @(negedge clk) drv_dir = 1'b0;
    @(negedge clk) chk("R7 edge1 unchanged", 8'(gates), 8'h9);
    @(negedge clk) chk("R7 edge2 both legs off", 8'(gates), 8'h0);
    repeat (DEAD - 1) @(negedge clk);
    chk("R7 last off edge", 8'(gates), 8'h0);
    @(negedge clk) chk("R7 make after gap", 8'(gates), 8'h6);

    // R9 sleep, ignored inputs, wake interval
    @(negedge clk) sleep_n = 1'b0;
    @(negedge clk) chk("R9 sleep state", 8'(br_state), 8'd5);
    @(negedge clk) begin
      chk("R9 sleep gates", 8'(gates), 8'h0);
      drv_en = 1'b0; decay_fast = 1'b0; chop_trip = 1'b1;
    end
    @(negedge clk) chop_trip = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 inputs ignored state", 8'(br_state), 8'd5);
    chk("R9 inputs ignored gates", 8'(gates), 8'h0);
    @(negedge clk) begin sleep_n = 1'b1; drv_en = 1'b1; drv_dir = 1'b1; end
    repeat (WAKE) @(negedge clk);
    chk("R9 still waking", 8'(br_state), 8'd5);
    @(negedge clk) chk("R9 wake done state", 8'(br_state), 8'd1);
    @(negedge clk) chk("R9 wake done gates", 8'(gates), 8'h9);

    // R8 asynchronous reset mid-drive
    @(negedge clk) #2 rst_n = 1'b0;
    #1;
    chk("R8 async gates", 8'(gates), 8'h0);
    chk("R8 async state", 8'(br_state), 8'd5);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) chk("R8 restart state", 8'(br_state), 8'd1);
    @(negedge clk) chk("R8 restart gates", 8'(gates), 8'h9);

    chk("R7 no leg overlap seen", 8'(overlap), 8'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied_n, bad_n);
    $finish;
  end

endmodule